// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block holds three clock-enable sets, one per power state: active, sleep and deep sleep. Each set has an enable bit for a watchdog unit, an enable bit for an analog-to-digital converter, and a limit on the converter's sampling rate. Software reaches the sets through a simple register port. The power-management logic gives the block the current power state and an automatic-gating flag. From these the block picks one set and drives registered clock-enable outputs and the converter rate from it.

The block also watches accesses aimed at the peripherals. When an access targets a unit whose clock enable output is low, the block raises a one-cycle bus fault. Everything starts gated after reset, so software must enable each unit before using it.

Top module: `pwr_clk_gate_ctrl`

## Requirements
- R1: After reset, both clock enables, the rate output and the fault output are 0, and all three sets read back as zero.
- R2: The sets are mapped at offset 0x100 (active), 0x110 (sleep) and 0x120 (deep sleep). Within each word, bit 3 is the watchdog enable, bit 16 is the converter enable and bits 11:8 are the rate field. All other bits read 0, and writing them has no effect.
- R3: A rate value above 2 (the maximum) is stored as 2. Values 0, 1 and 2 (125k, 250k and 500k samples/s) are stored unchanged, and rate_o never exceeds 2.
- R4: While auto_gate_i is 0, the active set drives the enables and the rate in every power state.
- R5: While auto_gate_i is 1, pwr_mode_i = 1 selects the sleep set and pwr_mode_i = 2 selects the deep-sleep set. Values 0 and 3 select the active set.
- R6: The clk_en_o bits (bit 0 is the watchdog, bit 1 is the converter) and rate_o are registered. After each edge they show the set chosen by auto_gate_i and pwr_mode_i at that edge, using the register contents from before that edge.
- R7: An access with acc_valid_i high and acc_unit_i set to 0 (watchdog) or 1 (converter), whose clk_en_o bit is 0 at that edge, makes acc_fault_o high for exactly the following cycle.
- R8: No fault is raised for an access to an enabled unit, for an acc_unit_i value of 2 or more, or when acc_valid_i is low.
- R9: A write to any offset other than the three mapped ones changes no stored state, and such offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| auto_gate_i | input | 1 | Automatic gating: use the sleep and deep-sleep sets |
| pwr_mode_i | input | 2 | Power state: 0 active, 1 sleep, 2 deep sleep |
| acc_valid_i | input | 1 | Peripheral access strobe |
| acc_unit_i | input | 2 | Target unit of the access |
| acc_fault_o | output | 1 | Bus fault pulse |
| clk_en_o | output | 2 | Clock enables: bit 0 watchdog, bit 1 converter |
| rate_o | output | 4 | Converter sample-rate limit |

## Verification
The hardest case to reach is the one-cycle window after a register write. In that cycle the stored set has already changed, but the enables and the fault decision still follow the old value. An access arriving in that cycle is easy to misjudge. The stimulus writes a set and then places peripheral accesses on the very next edges. A long pseudo-random phase also toggles power state, automatic gating, writes and accesses every cycle, so these windows occur many times, including the moment a mode switch and a write land on the same edge.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int RATE_W   = 4;
  localparam int NUM_SETS = 3;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2,
    PM_RSVD  = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              conv_en;
    logic              wdg_en;
  } gate_set_t;
endpackage

// File: rtl/pcg_regfile.sv
module pcg_regfile
  import pcg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          MAX_RATE  = 2,
  parameter int          WDG_BIT   = 3,
  parameter int          CONV_BIT  = 16,
  parameter int          RATE_LSB  = 8,
  parameter logic [11:0] RUN_OFF   = 12'h100,
  parameter logic [11:0] SLEEP_OFF = 12'h110,
  parameter logic [11:0] DEEP_OFF  = 12'h120
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output gate_set_t [NUM_SETS-1:0]       sets_o
);
  localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(MAX_RATE);

  function automatic logic [ADDR_W-1:0] set_off(input int s);
    case (s)
      0:       return ADDR_W'(RUN_OFF);
      1:       return ADDR_W'(SLEEP_OFF);
      default: return ADDR_W'(DEEP_OFF);
    endcase
  endfunction

  logic [RATE_W-1:0]   wr_rate, wr_rate_cl;
  logic [NUM_SETS-1:0] hit;
  logic                unused_wdata;

  assign wr_rate      = wdata_i[RATE_LSB +: RATE_W];
  assign wr_rate_cl   = (wr_rate > RATE_CAP) ? RATE_CAP : wr_rate;
  assign unused_wdata = ^wdata_i;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign hit[s] = (addr_i == set_off(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sets_o[s] <= '0;
      end else if (req_i && we_i && hit[s]) begin
        sets_o[s].wdg_en  <= wdata_i[WDG_BIT];
        sets_o[s].conv_en <= wdata_i[CONV_BIT];
        sets_o[s].rate    <= wr_rate_cl;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (hit[s]) begin
        rdata_o[WDG_BIT]             = sets_o[s].wdg_en;
        rdata_o[CONV_BIT]            = sets_o[s].conv_en;
        rdata_o[RATE_LSB +: RATE_W]  = sets_o[s].rate;
      end
    end
  end

  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit == '0) |=> $stable(sets_o)) else $error("unmapped write changed state"); // R9

  AST_STORED_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit[0]) |=> (sets_o[0].rate <= RATE_CAP)) else $error("rate not clamped"); // R3
endmodule

// File: rtl/pcg_mode_sel.sv
module pcg_mode_sel
  import pcg_pkg::*;
#(
  parameter int MAX_RATE  = 2,
  parameter int NUM_UNITS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  gate_set_t [NUM_SETS-1:0]  sets_i,
  input  logic                      auto_i,
  input  logic [1:0]                mode_i,
  output logic [NUM_UNITS-1:0]      en_o,
  output logic [RATE_W-1:0]         rate_o
);
  localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(MAX_RATE);

  pwr_mode_e mode;
  gate_set_t pick;

  assign mode = pwr_mode_e'(mode_i);

  always_comb begin
    pick = sets_i[0];
    if (auto_i) begin
      case (mode)
        PM_SLEEP: pick = sets_i[1];
        PM_DEEP:  pick = sets_i[2];
        default:  pick = sets_i[0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      rate_o <= '0;
    end else begin
      en_o   <= {pick.conv_en, pick.wdg_en};
      rate_o <= pick.rate;
    end
  end

  AST_MANUAL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> (en_o == {$past(sets_i[0].conv_en), $past(sets_i[0].wdg_en)})) else $error("manual mode not on run set"); // R4

  AST_SLEEP_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && mode_i == 2'd1) |=> (rate_o == $past(sets_i[1].rate))) else $error("sleep set not chosen"); // R5

  AST_RATE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_o <= RATE_CAP) else $error("rate above maximum"); // R3
endmodule

// File: rtl/pcg_fault_gen.sv
module pcg_fault_gen #(
  parameter int NUM_UNITS = 2,
  parameter int UNIT_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [UNIT_W-1:0]    unit_i,
  input  logic [NUM_UNITS-1:0] en_i,
  output logic                 fault_o
);
  localparam logic [UNIT_W-1:0] UNIT_LIM = UNIT_W'(NUM_UNITS);

  logic gated;

  always_comb begin
    gated = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_i == UNIT_W'(u) && !en_i[u]) gated = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= valid_i && gated;
  end

  AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(valid_i) && $past(unit_i) < UNIT_LIM)) else $error("fault without cause"); // R7

  AST_NO_FAULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || unit_i >= UNIT_LIM) |=> !fault_o) else $error("spurious fault"); // R8

  AST_NO_FAULT_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i < UNIT_LIM && en_i == '1) |=> !fault_o) else $error("fault on clocked unit"); // R8
endmodule

// File: rtl/pwr_clk_gate_ctrl.sv
module pwr_clk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          UNIT_W    = 2,
  parameter int          MAX_RATE  = 2,
  parameter int          WDG_BIT   = 3,
  parameter int          CONV_BIT  = 16,
  parameter int          RATE_LSB  = 8,
  parameter logic [11:0] RUN_OFF   = 12'h100,
  parameter logic [11:0] SLEEP_OFF = 12'h110,
  parameter logic [11:0] DEEP_OFF  = 12'h120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              auto_gate_i,
  input  logic [1:0]        pwr_mode_i,
  input  logic              acc_valid_i,
  input  logic [UNIT_W-1:0] acc_unit_i,
  output logic              acc_fault_o,
  output logic [1:0]        clk_en_o,
  output logic [RATE_W-1:0] rate_o
);
  localparam int NUM_UNITS = 2;

  gate_set_t [NUM_SETS-1:0] sets;

  pcg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_RATE(MAX_RATE),
    .WDG_BIT(WDG_BIT), .CONV_BIT(CONV_BIT), .RATE_LSB(RATE_LSB),
    .RUN_OFF(RUN_OFF), .SLEEP_OFF(SLEEP_OFF), .DEEP_OFF(DEEP_OFF)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .sets_o(sets)
  );

  pcg_mode_sel #(.MAX_RATE(MAX_RATE), .NUM_UNITS(NUM_UNITS)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .sets_i(sets),
    .auto_i(auto_gate_i), .mode_i(pwr_mode_i),
    .en_o(clk_en_o), .rate_o(rate_o)
  );

  pcg_fault_gen #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(acc_valid_i), .unit_i(acc_unit_i),
    .en_i(clk_en_o), .fault_o(acc_fault_o)
  );

  AST_FAULT_PULSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_unit_i == '0 && !clk_en_o[0]) |=> acc_fault_o) else $error("missed fault"); // R7
endmodule

// File: tb/pwr_clk_gate_ctrl_test.sv
module pwr_clk_gate_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        auto_g = 1'b0;
  logic [1:0]  mode = '0;
  logic        avalid = 1'b0;
  logic [1:0]  aunit = '0;
  logic        fault;
  logic [1:0]  en;
  logic [3:0]  rate;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  bit m_wdg[3];
  bit m_conv[3];
  int m_rate[3];
  bit [1:0] m_en;
  int m_rate_o;
  bit m_fault;

  always #4 clk = ~clk;

  pwr_clk_gate_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .auto_gate_i(auto_g), .pwr_mode_i(mode),
    .acc_valid_i(avalid), .acc_unit_i(aunit), .acc_fault_o(fault),
    .clk_en_o(en), .rate_o(rate)
  );

  task automatic check(input bit ok, input string req_s, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_s, what, act, exp);
    end
  endtask

  function automatic int set_idx(input logic [11:0] a);
    case (a)
      12'h100: return 0;
      12'h110: return 1;
      12'h120: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int s = set_idx(a);
    logic [31:0] v = '0;
    if (s >= 0) begin
      v[3] = m_wdg[s];
      v[16] = m_conv[s];
      v[11:8] = 4'(m_rate[s]);
    end
    return v;
  endfunction

  task automatic cyc();
    int sel;
    int s;
    bit nf;
    int wr;
    @(posedge clk);
    sel = 0;
    if (auto_g && mode == 2'd1) sel = 1;
    if (auto_g && mode == 2'd2) sel = 2;
    nf = avalid && (aunit < 2) && !m_en[aunit[0]];
    m_fault = nf;
    m_en = {m_conv[sel], m_wdg[sel]};
    m_rate_o = m_rate[sel];
    s = set_idx(addr);
    if (req && we && s >= 0) begin
      m_wdg[s] = wdata[3];
      m_conv[s] = wdata[16];
      wr = int'(wdata[11:8]);
      m_rate[s] = (wr > 2) ? 2 : wr;
    end
    @(negedge clk);
    check(en == m_en, tag, "clk_en_o", en, m_en);
    check(int'(rate) == m_rate_o, tag, "rate_o", rate, m_rate_o);
    check(fault == m_fault, tag, "acc_fault_o", fault, m_fault);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    cyc();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req_s);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    check(rdata == exp_rd(a), req_s, "reg_rdata_o", rdata, exp_rd(a));
    req = 1'b0;
  endtask

  task automatic access(input logic [1:0] u);
    avalid = 1'b1; aunit = u;
    cyc();
    avalid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf = 32'h1d87_2b41;
    for (int i = 0; i < 3; i++) begin m_wdg[i] = 0; m_conv[i] = 0; m_rate[i] = 0; end
    m_en = '0; m_rate_o = 0; m_fault = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(en == 2'b00, "R1", "clk_en_o in reset", en, 0);
    check(rate == 4'd0, "R1", "rate_o in reset", rate, 0);
    check(fault == 1'b0, "R1", "acc_fault_o in reset", fault, 0);
    rst_n = 1'b1;
    tag = "R1";
    cyc();
    rd_chk(12'h100, "R1"); rd_chk(12'h110, "R1"); rd_chk(12'h120, "R1");
    // R7 access to a gated unit straight after reset
    tag = "R7";
    access(2'd0);
    cyc();
    access(2'd1);
    cyc();
    // R2 / R3 field positions and clamp
    tag = "R2";
    wr_reg(12'h100, 32'hFFFF_FFFF);
    rd_chk(12'h100, "R2");
    check(rdata == 32'h0001_0208, "R3", "clamped readback", rdata, 32'h0001_0208);
    wr_reg(12'h100, 32'h0000_0108);
    rd_chk(12'h100, "R2");
    check(rdata == 32'h0000_0108, "R2", "watchdog+rate1 readback", rdata, 32'h0000_0108);
    wr_reg(12'h110, 32'h0001_0F00);
    rd_chk(12'h110, "R3");
    wr_reg(12'h120, 32'h0000_0208);
    rd_chk(12'h120, "R2");
    // R9 unmapped offsets
    tag = "R9";
    wr_reg(12'h104, 32'hFFFF_FFFF);
    wr_reg(12'h130, 32'h0000_0000);
    rd_chk(12'h104, "R9"); rd_chk(12'h130, "R9");
    rd_chk(12'h100, "R9"); rd_chk(12'h110, "R9"); rd_chk(12'h120, "R9");
    // R4 manual gating: run set in all modes
    tag = "R4";
    auto_g = 1'b0;
    for (int m = 0; m < 4; m++) begin mode = 2'(m); cyc(); cyc(); end
    // R5 automatic gating
    tag = "R5";
    auto_g = 1'b1;
    for (int m = 0; m < 4; m++) begin mode = 2'(m); cyc(); cyc(); end
    // R7 / R8 faults in each mode
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      cyc();
      for (int u = 0; u < 4; u++) begin
        tag = (u < 2) ? "R7" : "R8";
        access(2'(u));
      end
    end
    // R8 enabled unit, and back-to-back write then access
    tag = "R8";
    mode = 2'd0;
    wr_reg(12'h100, 32'h0001_0008);
    access(2'd1);
    access(2'd1);
    tag = "R6";
    wr_reg(12'h100, 32'h0000_0000);
    access(2'd0);
    access(2'd0);
    // R6 mixed random traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      req = lf[0];
      we = lf[1];
      case (lf[5:4])
        2'd0: addr = 12'h100;
        2'd1: addr = 12'h110;
        2'd2: addr = 12'h120;
        default: addr = 12'h118;
      endcase
      wdata = {lf[15:0], lf[31:16]} ^ {lf[7:0], lf[31:8]};
      auto_g = lf[9];
      mode = lf[11:10];
      avalid = lf[12];
      aunit = lf[14:13];
      if (!we) begin
        #1;
        check(rdata == exp_rd(addr), "R2", "random readback", rdata, exp_rd(addr));
      end
      cyc();
    end
    req = 1'b0; we = 1'b0; avalid = 1'b0;
    cyc();
    finish_run();
  end
endmodule